// File: doc/BRIEF.md
# Register-Fed Two-Channel CIC Decimator

This block is a two-channel integrate-and-decimate filter whose samples come from a register interface. Software loads a 16-bit signed sample into each channel's input register and then sets a self-clearing update command. The block then takes a fixed two cycles to fold one sample into the integrators of every enabled channel. It also steps a decimation down-counter. When that counter reaches zero, the block is at a decimation boundary. There it publishes each channel's running sum to a visible accumulator and to an output register, sets a done flag and pulses an output-ready interrupt. If the previous outputs were still unread at that point, it also sets a sticky overflow flag and pulses an overflow interrupt.

Each sample can be negated before integration (sign demodulation). The polarity comes either from a software bit or from an external pin. One order bit selects a single integrator or two cascaded integrators. The register port uses plain read and write strobes. A read of an output register is what marks that output as consumed.

Top module: `cic_regfeed_top`

## Requirements
- R1: A write to an input register (address 3 for channel 0, address 4 for channel 1, low 16 bits) starts nothing: busy stays 0 and no interrupt fires. A sample run covers every enabled channel whether or not its input register was rewritten since the previous run.
- R2: Writing the control register (address 0) with bit 7 = 1 starts a run, but only when the block is idle. Status busy (address 2, bit 17) is then 1 for exactly two cycles. Control bit 7 reads 1 during the run and returns to 0 by itself. `irq_ipc` pulses for one cycle in the first cycle after busy drops. An update requested while busy is ignored.
- R3: The decimation register (address 1, bits 11:0) holds the filter length minus one. The first run of a period loads the counter (status bits 11:0) from it. Each later run decrements it, and the run that brings it to 0 is the decimation boundary.
- R4: At a boundary, done (status bit 16) is set and `irq_ordy` pulses in the same cycle as `irq_ipc`. Done clears only once the output register of every channel enabled for that run has been read (address 7 for channel 0, address 8 for channel 1).
- R5: At a boundary where some output from the previous boundary is still unread, overflow (status bit 18) is set and `irq_ovf` pulses together with `irq_ordy`. Overflow stays set until status is written with bit 18 = 1. A read of the last pending output that falls in the same cycle as the boundary counts as done in time, so no overflow results.
- R6: Each channel's 32-bit accumulator holds the sum of every sample it has processed and is never cleared. Its visible register (address 5 for channel 0, address 6 for channel 1) changes only at a boundary. At a boundary the output register of each enabled channel is loaded with that same newly published value. All sums wrap modulo 2^32.
- R7: Control bit 0 enables the filter, and an update is accepted only when it is already set and written as 1. Control bits 1 and 2 enable channel 0 and channel 1. A channel disabled for a run keeps its integrators, accumulator and output unchanged.
- R8: Control bit 3 = 0 publishes the first integrator. Control bit 3 = 1 publishes the second of two cascaded integrators, which always integrate.
- R9: With control bit 4 (demodulation) set, the sample is negated when the polarity is 1. The polarity is the `pol_in` pin if control bit 5 = 1, and control bit 6 if control bit 5 = 0. Samples are sign-extended from 16 to 32 bits.
- R10: Clearing the filter enable resets the counter, busy, done and overflow within one cycle, and the accumulators and outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (read side effects) |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| pol_in | input | 1 | External demodulation polarity |
| irq_ipc | output | 1 | One-cycle pulse: sample run complete |
| irq_ordy | output | 1 | One-cycle pulse: output ready |
| irq_ovf | output | 1 | One-cycle pulse: output overflow |

## Verification
The decimation boundary and a software read of an output register can land on the same clock edge. The result then depends on whether the read is counted before the new outputs are marked pending. The bench provokes this by placing the read of the last pending output exactly on the edge that ends the boundary run. It judges the result by checks on four things: that the read returns the old output value, that `irq_ovf` stays low while `irq_ordy` pulses, and that status then shows done set with overflow clear.

// File: rtl/cic_regfeed_pkg.sv
package cic_regfeed_pkg;

  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] RA_DECIM = 4'd1;
  localparam logic [ADDR_W-1:0] RA_STAT  = 4'd2;
  localparam logic [ADDR_W-1:0] RA_DIN0  = 4'd3;
  localparam logic [ADDR_W-1:0] RA_ACC0  = 4'd5;
  localparam logic [ADDR_W-1:0] RA_OUT0  = 4'd7;

  localparam int unsigned UPD_BIT  = 7;
  localparam int unsigned DONE_BIT = 16;
  localparam int unsigned BUSY_BIT = 17;
  localparam int unsigned OVF_BIT  = 18;

  // control fields, filt_en in bit 0 up to pol_ovr in bit 6
  typedef struct packed {
    logic       pol_ovr;
    logic       pol_sel;
    logic       demod;
    logic       order;
    logic [1:0] ch_en;
    logic       filt_en;
  } ctrl_t;

endpackage

// File: rtl/cic_seq.sv
module cic_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  output logic busy,
  output logic step1,
  output logic step2
);
  logic ph_q;

  assign step1 = busy & ~ph_q & ~clr;
  assign step2 = busy &  ph_q & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph_q <= 1'b0;
    end else if (clr) begin
      busy <= 1'b0;
      ph_q <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      ph_q <= 1'b0;
    end else if (step1) begin
      ph_q <= 1'b1;
    end else if (step2) begin
      busy <= 1'b0;
      ph_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] decim,
  output logic [CNT_W-1:0] cnt,
  output logic             bnd
);
  logic             first_q;
  logic [CNT_W-1:0] nxt;

  function automatic logic [CNT_W-1:0] next_count(input logic first,
      input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] len_m1);
    return first ? len_m1 : cur - 1'b1;
  endfunction

  assign nxt = next_count(first_q, cnt, decim);
  assign bnd = step && (nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      first_q <= 1'b1;
    end else if (clr) begin
      cnt     <= '0;
      first_q <= 1'b1;
    end else if (step) begin
      cnt     <= nxt;
      first_q <= (nxt == '0);
    end
  end
endmodule

// File: rtl/cic_chan.sv
module cic_chan #(
  parameter int DIN_W = 16,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en,
  input  logic [DIN_W-1:0] din,
  input  logic             neg,
  input  logic             step1,
  input  logic             step2,
  input  logic             publish,
  input  logic             order,
  output logic [ACC_W-1:0] acc_vis,
  output logic [ACC_W-1:0] dout
);
  localparam int EXT_W = ACC_W - DIN_W;

  logic             act_q;
  logic [ACC_W-1:0] x_q, s1_q, s2_q, s2_nxt, pub;

  function automatic logic [ACC_W-1:0] widen(input logic [DIN_W-1:0] v, input logic n);
    logic [ACC_W-1:0] e;
    e = {{EXT_W{v[DIN_W-1]}}, v};
    return n ? ('0 - e) : e;
  endfunction

  assign s2_nxt = s2_q + s1_q;
  assign pub    = order ? s2_nxt : s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      x_q     <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
      acc_vis <= '0;
      dout    <= '0;
    end else begin
      if (load) begin
        act_q <= en;
        x_q   <= widen(din, neg);
      end
      if (step1 && act_q) s1_q <= s1_q + x_q;
      if (step2 && act_q) s2_q <= s2_nxt;
      if (publish && act_q) begin
        acc_vis <= pub;
        dout    <= pub;
      end
    end
  end
endmodule

// File: rtl/cic_regfeed_top.sv
module cic_regfeed_top
  import cic_regfeed_pkg::*;
#(
  parameter int DIN_W = 16,
  parameter int ACC_W = 32,
  parameter int CNT_W = 12,
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              pol_in,
  output logic              irq_ipc,
  output logic              irq_ordy,
  output logic              irq_ovf
);
  localparam int NCH = 2;

  ctrl_t            ctrl_q, ctrl_wr;
  logic             upd_q, ovf_q, done_w;
  logic [CNT_W-1:0] decim_q, cnt_w;
  logic [DIN_W-1:0] din_q [NCH];
  logic [ACC_W-1:0] acc_v [NCH];
  logic [ACC_W-1:0] dout_v [NCH];
  logic [NCH-1:0]   unread_q, rd_clr, unread_left;
  logic             wr_ctrl, start_w, clr_w, neg_w, busy_w, step1_w, step2_w, bnd_w, ovf_ev;

  function automatic logic pick_sign(input ctrl_t c, input logic pin);
    return c.demod && (c.pol_sel ? pin : c.pol_ovr);
  endfunction

  assign ctrl_wr = ctrl_t'(wr_data[6:0]);
  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);
  assign start_w = wr_ctrl && wr_data[UPD_BIT] && ctrl_q.filt_en && ctrl_wr.filt_en && !busy_w;
  assign clr_w   = !ctrl_q.filt_en;
  assign neg_w   = pick_sign(ctrl_wr, pol_in);

  cic_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w), .clr(clr_w),
    .busy(busy_w), .step1(step1_w), .step2(step2_w)
  );

  cic_decim #(.CNT_W(CNT_W)) u_decim (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .step(step2_w),
    .decim(decim_q), .cnt(cnt_w), .bnd(bnd_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cic_chan #(.DIN_W(DIN_W), .ACC_W(ACC_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .load(start_w), .en(ctrl_wr.ch_en[g]),
      .din(din_q[g]), .neg(neg_w), .step1(step1_w), .step2(step2_w),
      .publish(bnd_w), .order(ctrl_q.order),
      .acc_vis(acc_v[g]), .dout(dout_v[g])
    );

    assign rd_clr[g] = rd_en && (rd_addr == RA_OUT0 + ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) din_q[g] <= '0;
      else if (wr_en && wr_addr == RA_DIN0 + ADDR_W'(g)) din_q[g] <= wr_data[DIN_W-1:0];
    end
  end

  assign unread_left = unread_q & ~rd_clr;
  assign ovf_ev      = bnd_w && (unread_left != '0);
  assign done_w      = (unread_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      upd_q    <= 1'b0;
      decim_q  <= '0;
      unread_q <= '0;
      ovf_q    <= 1'b0;
      irq_ipc  <= 1'b0;
      irq_ordy <= 1'b0;
      irq_ovf  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_wr;
      if (wr_en && wr_addr == RA_DECIM) decim_q <= wr_data[CNT_W-1:0];
      if (start_w) upd_q <= 1'b1;
      else if (step2_w || clr_w) upd_q <= 1'b0;
      if (clr_w) unread_q <= '0;
      else if (bnd_w) unread_q <= ctrl_q.ch_en;
      else unread_q <= unread_left;
      if (clr_w) ovf_q <= 1'b0;
      else if (ovf_ev) ovf_q <= 1'b1;
      else if (wr_en && wr_addr == RA_STAT && wr_data[OVF_BIT]) ovf_q <= 1'b0;
      irq_ipc  <= step2_w;
      irq_ordy <= bnd_w;
      irq_ovf  <= ovf_ev;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL:  begin rd_data[6:0] = ctrl_q; rd_data[UPD_BIT] = upd_q; end
      RA_DECIM: rd_data[CNT_W-1:0] = decim_q;
      RA_STAT:  begin
        rd_data[CNT_W-1:0] = cnt_w;
        rd_data[DONE_BIT]  = done_w;
        rd_data[BUSY_BIT]  = busy_w;
        rd_data[OVF_BIT]   = ovf_q;
      end
      RA_DIN0:       rd_data[DIN_W-1:0] = din_q[0];
      RA_DIN0 + 4'd1: rd_data[DIN_W-1:0] = din_q[1];
      RA_ACC0:       rd_data = BUS_W'(acc_v[0]);
      RA_ACC0 + 4'd1: rd_data = BUS_W'(acc_v[1]);
      RA_OUT0:       rd_data = BUS_W'(dout_v[0]);
      RA_OUT0 + 4'd1: rd_data = BUS_W'(dout_v[1]);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cic_regfeed_chk.sv
module cic_regfeed_chk
  import cic_regfeed_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              bnd,
  input logic              done,
  input logic              ovf,
  input logic              filt_en,
  input logic              irq_ipc,
  input logic              irq_ordy,
  input logic              irq_ovf,
  input logic [31:0]       acc0
);
  p_din_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == RA_DIN0 || wr_addr == RA_DIN0 + 4'd1) && !busy) |=> !busy);

  p_busy_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  p_ipc_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ipc |-> (!busy && $past(busy)));

  p_ordy_with_ipc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ordy |-> irq_ipc);

  p_done_from_bnd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bnd));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> (ovf && irq_ordy));

  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(acc0));

  p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |=> !busy);
endmodule

bind cic_regfeed_top cic_regfeed_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .busy(busy_w), .bnd(bnd_w), .done(done_w), .ovf(ovf_q),
  .filt_en(ctrl_q.filt_en), .irq_ipc(irq_ipc), .irq_ordy(irq_ordy),
  .irq_ovf(irq_ovf), .acc0(acc_v[0])
);

// File: tb/cic_regfeed_tb.sv
`timescale 1ns/1ps
module cic_regfeed_top_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, pol_in = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_ipc, irq_ordy, irq_ovf;

  int n_checks = 0, n_err = 0;

  typedef struct packed { logic bnd; logic ovf; } exp_t;
  exp_t sb_q[$];

  logic [31:0] m_s1 [2], m_s2 [2], m_out [2];
  logic [15:0] m_din [2];
  logic [11:0] m_cnt = '0, m_len = '0;
  bit          m_first = 1'b1, m_ovf = 1'b0;
  bit   [1:0]  m_unread = '0;

  cic_regfeed_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pol_in(pol_in),
    .irq_ipc(irq_ipc), .irq_ordy(irq_ordy), .irq_ovf(irq_ovf)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: every completed run pops one expected item
  always @(negedge clk) begin
    if (rst_n && irq_ipc) begin
      if (sb_q.size() == 0) check("R2 unexpected run", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check("R4 irq_ordy", {31'd0, irq_ordy}, {31'd0, e.bnd});
        check("R5 irq_ovf", {31'd0, irq_ovf}, {31'd0, e.ovf});
      end
    end
  end

  // tasks are entered at a falling edge and return at the next one
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [6:0] mk(input bit en, input bit [1:0] ch, input bit ord,
                                    input bit dm, input bit ps, input bit po);
    return {po, ps, dm, ord, ch, en};
  endfunction

  function automatic logic [31:0] stat_exp(input bit busy);
    return {13'd0, m_ovf, busy, (m_unread != 0), 4'd0, m_cnt};
  endfunction

  task automatic set_din(input int ch, input logic [15:0] v);
    m_din[ch] = v;
    wr(4'd3 + 4'(ch), {16'd0, v});
  endtask

  // reference model of one run, written from the requirements
  task automatic model_run(input logic [6:0] c, input bit [1:0] rclr);
    logic [31:0] x;
    bit neg, b;
    neg = c[4] && (c[5] ? pol_in : c[6]);
    for (int ch = 0; ch < 2; ch++) begin
      if (c[1+ch]) begin
        x = {{16{m_din[ch][15]}}, m_din[ch]};
        if (neg) x = -x;
        m_s1[ch] = m_s1[ch] + x;
        m_s2[ch] = m_s2[ch] + m_s1[ch];
      end
    end
    m_cnt = m_first ? m_len : m_cnt - 12'd1;
    b = (m_cnt == 0);
    m_first = b;
    m_unread = m_unread & ~rclr;
    if (b) begin
      exp_t e;
      e.bnd = 1'b1; e.ovf = (m_unread != 0);
      if (e.ovf) m_ovf = 1'b1;
      sb_q.push_back(e);
      m_unread = c[2:1];
      for (int ch = 0; ch < 2; ch++)
        if (c[1+ch]) m_out[ch] = c[3] ? m_s2[ch] : m_s1[ch];
    end else begin
      sb_q.push_back(2'b00);
    end
  endtask

  // one run; optionally reads an output on the edge that ends the run
  task automatic run(input logic [6:0] c, input bit same_rd, input int rch);
    logic [31:0] v, old;
    old = m_out[rch];
    model_run(c, same_rd ? 2'(1 << rch) : 2'b00);
    wr(4'd0, {24'd0, 1'b1, c});
    rd(4'd2, v);
    check("R2 busy during run", {31'd0, v[17]}, 32'd1);
    if (same_rd) begin
      rd(4'd7 + 4'(rch), v);
      check("R5 same-cycle read value", v, old);
    end else @(negedge clk);
    check("R2 irq_ipc after run", {31'd0, irq_ipc}, 32'd1);
    rd(4'd0, v);
    check("R2 update self-clears", {31'd0, v[7]}, 32'd0);
  endtask

  task automatic read_out(input int ch, input string tag);
    logic [31:0] v;
    rd(4'd7 + 4'(ch), v);
    m_unread[ch] = 1'b0;
    check(tag, v, m_out[ch]);
  endtask

  task automatic chk_stat(input string tag);
    logic [31:0] v;
    rd(4'd2, v);
    check(tag, v, stat_exp(1'b0));
  endtask

  task automatic chk_acc(input int ch, input string tag);
    logic [31:0] v;
    rd(4'd5 + 4'(ch), v);
    check(tag, v, ch == 0 ? m_out[0] : m_out[1]);
  endtask

  initial begin
    logic [31:0] v;
    logic [6:0]  c;
    for (int i = 0; i < 2; i++) begin m_s1[i] = '0; m_s2[i] = '0; m_out[i] = '0; m_din[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk_stat("R4 reset status");
    check("R2 reset irqs", {29'd0, irq_ipc, irq_ordy, irq_ovf}, 32'd0);
    chk_acc(0, "R6 reset acc0");

    // configure: length 4, both channels, single integrator
    m_len = 12'd3;
    wr(4'd1, 32'd3);
    c = mk(1, 2'b11, 0, 0, 0, 0);
    wr(4'd0, {25'd0, c});
    set_din(0, 16'd5);
    set_din(1, 16'hFFFD);
    @(negedge clk);
    check("R1 din write starts nothing", {31'd0, irq_ipc}, 32'd0);
    chk_stat("R1 status idle after din write");

    // R3 counter walk, R6 visible acc held until boundary
    run(c, 0, 0); chk_stat("R3 count loaded");
    run(c, 0, 0); chk_stat("R3 count dec");
    run(c, 0, 0); chk_stat("R3 count dec again");
    chk_acc(0, "R6 acc held before boundary");
    run(c, 0, 0); chk_stat("R4 done at boundary");
    chk_acc(0, "R6 acc0 published");
    chk_acc(1, "R6 acc1 published negative");
    check("R1 sum of unrewritten samples", m_out[0], 32'd20);
    read_out(0, "R6 out0 value");
    chk_stat("R4 done held with out1 unread");
    read_out(1, "R6 out1 value");
    chk_stat("R4 done cleared");

    // R5 overflow: two boundaries with no reads between
    for (int i = 0; i < 8; i++) run(c, 0, 0);
    chk_stat("R5 overflow set");
    wr(4'd2, 32'h0004_0000);
    m_ovf = 1'b0;
    chk_stat("R5 overflow cleared by write");

    // R5 same-cycle read of last pending output at the boundary
    read_out(0, "R6 out0 before same-cycle case");
    for (int i = 0; i < 3; i++) run(c, 0, 0);
    run(c, 1, 1);
    chk_stat("R5 no overflow on same-cycle read");
    read_out(0, "R6 out0 after same-cycle");
    read_out(1, "R6 out1 after same-cycle");

    // R2 update while busy is ignored
    model_run(c, 2'b00);
    wr(4'd0, {24'd0, 1'b1, c});
    wr(4'd0, {24'd0, 1'b1, c});
    repeat (4) @(negedge clk);
    chk_stat("R2 second update ignored");

    // R10 disable clears flags, keeps accumulators
    wr(4'd0, {25'd0, mk(0, 2'b11, 0, 0, 0, 0)});
    @(negedge clk);
    m_cnt = '0; m_first = 1'b1; m_unread = '0; m_ovf = 1'b0;
    chk_stat("R10 status cleared");
    chk_acc(0, "R10 acc0 kept");
    wr(4'd0, {24'd0, 1'b1, 7'(mk(0, 2'b11, 0, 0, 0, 0))});
    repeat (3) @(negedge clk);
    chk_stat("R7 update ignored when filter off");

    // R8 cascade with length 1, R7 channel 1 disabled
    m_len = '0;
    wr(4'd1, 32'd0);
    c = mk(1, 2'b01, 1, 0, 0, 0);
    wr(4'd0, {25'd0, c});
    set_din(0, 16'd3);
    set_din(1, 16'd100);
    run(c, 0, 0);
    run(c, 0, 0);
    chk_acc(0, "R8 second-stage published");
    chk_acc(1, "R7 disabled channel unchanged");
    chk_stat("R5 overflow from unread cascade output");
    read_out(0, "R8 out0 second stage");
    chk_stat("R7 done clears with only enabled channel read");

    // R9 demodulation polarity sources
    c = mk(1, 2'b01, 0, 1, 0, 1);
    run(c, 0, 0);
    read_out(0, "R9 override polarity negates");
    pol_in = 1'b1;
    c = mk(1, 2'b01, 0, 1, 1, 0);
    run(c, 0, 0);
    read_out(0, "R9 pin polarity negates");
    pol_in = 1'b0;
    run(c, 0, 0);
    read_out(0, "R9 pin polarity zero passes");
    wr(4'd2, 32'h0004_0000);
    m_ovf = 1'b0;
    chk_stat("R5 final status");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", sb_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule